// File: doc/BRIEF.md
# DMA Stall Address Controller

This block lets one producing DMA channel and one consuming DMA channel share a memory buffer without the consumer overtaking the producer. Software writes an 8-bit control word. One field of that word picks which of three producing channels publishes a watermark, called the stall address. A second field picks which of three consuming channels is checked against that watermark. Each producing channel reports progress events: its memory address, its remaining quadword count, its transfer mode and its tag word. The selected producer moves the watermark forward at defined points in its transfer.

Each consuming channel raises a service request together with the address, count, mode and tag of the read it plans next. When the selected consumer's planned range would end past the watermark, the block holds that consumer. A hold state machine has two states, `ST_FREE` and `ST_HELD`, and three named transitions:
- BLOCK (`ST_FREE` to `ST_HELD`): a checked request whose range overruns the watermark.
- RELEASE (`ST_HELD` to `ST_FREE`): a later request from the held channel that no longer overruns, or to which the check does not apply.
- DROP (`ST_HELD` to `ST_FREE`): the drain field of the control word no longer names the held channel.

Entering the hold sets a sticky status bit. Software clears that bit with a one-cycle clear pulse. A mask bit gates the status bit onto the interrupt line.

Top module: `dma_stall_ctrl`

## Requirements
- R1: After reset the stall address is 0, all hold outputs are 0, and the status bit and the interrupt are 0.
- R2: Control bits 5:4 select the producing channel. Code k (1..3) selects producer k-1 and code 0 selects none. Events from producers that are not selected leave the stall address unchanged. A control write takes effect from the next cycle.
- R3: The stall address is loaded with the producer's address in the cycle after an event whose remaining count is 0. This happens in normal mode (mode 0), or in chain mode (mode 1) when the tag ID is 0. The tag ID is bits 30:28 of the tag word. An event with any other tag ID, or with a nonzero count, does not load.
- R4: A chain-mode event flagged as a packet start, with tag ID 0, loads the producer's current address. It does not load the packet's end address.
- R5: In interleave mode (mode 2), an event with a remaining count of 0 loads the producer's address.
- R6: Control bits 7:6 select the consuming channel. Code k (1..3) selects consumer k-1 and code 0 selects none. Only the selected consumer can be held, and at most one hold output is high at a time.
- R7: The range check applies only in normal mode, or in chain mode with tag ID 4. A request in any other mode, or with any other tag, is never held.
- R8: The planned end is address + 16·n for a planned size of n quadwords. A consumer is held, from the cycle after its request, when the end is strictly greater than the stall address. An end equal to the stall address proceeds.
- R9: For consumer 2, the planned size is the smaller of its remaining count and its free FIFO words divided by four. For the other consumers, the planned size is the count.
- R10: A held consumer is re-checked on each request and released as soon as its end no longer exceeds the stall address. Changing the drain field away from the held channel also releases it.
- R11: The status bit is set only on entry into the hold. It stays set until a clear pulse. A new entry in the same cycle as a clear leaves the bit set.
- R12: The interrupt equals the status bit gated by control bit 0 (the mask, 1 = enabled).
- R13: A consumer request in the same cycle as a watermark update is judged against the stall address from before that update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 8 | Control word: [7:6] drain select, [5:4] source select, [0] interrupt mask |
| stat_clr | input | 1 | Clear pulse for the stall status bit |
| prod_valid | input | 3 | Per-producer progress event valid |
| prod_start | input | 3 | Event marks the start of a chain packet |
| prod_addr | input | 3x32 | Producer current memory address |
| prod_qwc | input | 3x16 | Producer remaining quadword count |
| prod_mode | input | 3x2 | Producer mode: 0 normal, 1 chain, 2 interleave |
| prod_tag | input | 3x32 | Producer active tag word |
| cons_req | input | 3 | Per-consumer service request |
| cons_addr | input | 3x32 | Consumer planned start address |
| cons_qwc | input | 3x16 | Consumer remaining quadword count |
| cons_mode | input | 3x2 | Consumer mode |
| cons_tag | input | 3x32 | Consumer active tag word |
| fifo_free | input | 8 | Free FIFO words of consumer 2 |
| stall_addr_o | output | 32 | Current stall address |
| drain_hold_o | output | 3 | Per-consumer hold |
| stall_status_o | output | 1 | Sticky stall status bit |
| stall_irq_o | output | 1 | Masked stall interrupt |

## Verification
A watermark update and a range check can fall in the same cycle. The bench provokes this by presenting a producer completion at a higher address together with a held consumer's request whose end equals that new address. The hold must persist for that cycle because the check sees the old watermark, and it must release on the next request. A status clear pulse is also applied in the same cycle as a fresh BLOCK, and the bit must remain set.

// File: rtl/dma_stall_pkg.sv
package dma_stall_pkg;

    typedef enum logic [1:0] {
        XM_NORMAL = 2'd0,
        XM_CHAIN  = 2'd1,
        XM_INTLV  = 2'd2,
        XM_RSVD   = 2'd3
    } xfer_mode_e;

    typedef enum logic {
        ST_FREE = 1'b0,
        ST_HELD = 1'b1
    } hold_state_e;

    localparam int          TAG_ID_LSB  = 28;
    localparam logic [2:0]  TAG_PUBLISH = 3'd0;
    localparam logic [2:0]  TAG_GUARDED = 3'd4;

    function automatic logic [2:0] tag_id(input logic [31:0] word);
        return word[TAG_ID_LSB +: 3];
    endfunction

endpackage

// File: rtl/stall_src_track.sv
module stall_src_track
    import dma_stall_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int AW   = 32,
    parameter int CW   = 16,
    parameter int SELW = 2
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [SELW-1:0]          src_sel,
    input  logic [NCH-1:0]           p_valid,
    input  logic [NCH-1:0]           p_start,
    input  logic [NCH-1:0][AW-1:0]   p_addr,
    input  logic [NCH-1:0][CW-1:0]   p_qwc,
    input  logic [NCH-1:0][1:0]      p_mode,
    input  logic [NCH-1:0][31:0]     p_tag,
    output logic [AW-1:0]            stall_addr
);

    logic [NCH-1:0] load_hit;
    logic           load_any;
    logic [AW-1:0]  load_val;

    for (genvar i = 0; i < NCH; i++) begin : g_prod
        logic selected;
        logic done;
        logic publish_tag;
        logic hit_start;
        logic hit_done;
        logic hit_intlv;

        assign selected    = (src_sel == SELW'(i + 1));
        assign done        = (p_qwc[i] == '0);
        assign publish_tag = (tag_id(p_tag[i]) == TAG_PUBLISH);
        assign hit_start   = p_start[i] && (p_mode[i] == XM_CHAIN) && publish_tag;
        assign hit_intlv   = done && (p_mode[i] == XM_INTLV);
        assign hit_done    = done && ((p_mode[i] == XM_NORMAL) ||
                                      ((p_mode[i] == XM_CHAIN) && publish_tag));
        assign load_hit[i] = selected && p_valid[i] && (hit_start || hit_intlv || hit_done);
    end

    always_comb begin
        load_any = 1'b0;
        load_val = '0;
        for (int i = 0; i < NCH; i++) begin
            if (load_hit[i]) begin
                load_any = 1'b1;
                load_val = p_addr[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_addr <= '0;
        end else if (load_any) begin
            stall_addr <= load_val;
        end
    end

endmodule

// File: rtl/stall_drain_check.sv
module stall_drain_check
    import dma_stall_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int FW      = 8,
    parameter int SELW    = 2,
    parameter int FIFO_CH = 2
) (
    input  logic [SELW-1:0]          drain_sel,
    input  logic [NCH-1:0]           c_req,
    input  logic [NCH-1:0][AW-1:0]   c_addr,
    input  logic [NCH-1:0][CW-1:0]   c_qwc,
    input  logic [NCH-1:0][1:0]      c_mode,
    input  logic [NCH-1:0][31:0]     c_tag,
    input  logic [FW-1:0]            c_fifo_free,
    input  logic [AW-1:0]            stall_addr,
    output logic                     chk_req,
    output logic                     chk_applies,
    output logic                     chk_block
);

    localparam int EW = AW + 1;

    logic [NCH-1:0] ch_applies;
    logic [NCH-1:0] ch_block;

    for (genvar i = 0; i < NCH; i++) begin : g_cons
        logic [CW-1:0] size;
        logic [EW-1:0] end_addr;

        if (i == FIFO_CH) begin : g_fifo_lim
            logic [CW-1:0] room;
            assign room = CW'(c_fifo_free >> 2);
            assign size = (c_qwc[i] < room) ? c_qwc[i] : room;
        end else begin : g_plain
            assign size = c_qwc[i];
        end

        assign end_addr      = EW'(c_addr[i]) + (EW'(size) << 4);
        assign ch_block[i]   = end_addr > EW'(stall_addr);
        assign ch_applies[i] = (c_mode[i] == XM_NORMAL) ||
                               ((c_mode[i] == XM_CHAIN) && (tag_id(c_tag[i]) == TAG_GUARDED));
    end

    always_comb begin
        chk_req     = 1'b0;
        chk_applies = 1'b0;
        chk_block   = 1'b0;
        for (int i = 0; i < NCH; i++) begin
            if (drain_sel == SELW'(i + 1)) begin
                chk_req     = c_req[i];
                chk_applies = ch_applies[i];
                chk_block   = ch_block[i];
            end
        end
    end

endmodule

// File: rtl/stall_hold_fsm.sv
module stall_hold_fsm
    import dma_stall_pkg::*;
#(
    parameter int NCH  = 3,
    parameter int SELW = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [SELW-1:0] drain_sel,
    input  logic            chk_req,
    input  logic            chk_applies,
    input  logic            chk_block,
    output logic [NCH-1:0]  hold_vec,
    output logic            enter
);

    hold_state_e     state_q, state_d;
    logic [SELW-1:0] held_q, held_d;

    always_comb begin
        state_d = state_q;
        held_d  = held_q;
        unique case (state_q)
            ST_FREE: begin
                if (chk_req && chk_applies && chk_block) begin
                    state_d = ST_HELD;
                    held_d  = drain_sel;
                end
            end
            ST_HELD: begin
                if (drain_sel != held_q) begin
                    state_d = ST_FREE;
                end else if (chk_req && !(chk_applies && chk_block)) begin
                    state_d = ST_FREE;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_FREE;
            held_q  <= '0;
        end else begin
            state_q <= state_d;
            held_q  <= held_d;
        end
    end

    always_comb begin
        enter    = (state_q == ST_FREE) && (state_d == ST_HELD);
        hold_vec = '0;
        for (int i = 0; i < NCH; i++) begin
            hold_vec[i] = (state_q == ST_HELD) && (held_q == SELW'(i + 1));
        end
    end

endmodule

// File: rtl/dma_stall_ctrl.sv
module dma_stall_ctrl
    import dma_stall_pkg::*;
#(
    parameter int NCH     = 3,
    parameter int AW      = 32,
    parameter int CW      = 16,
    parameter int FW      = 8,
    parameter int FIFO_CH = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    ctl_we,
    input  logic [7:0]              ctl_wdata,
    input  logic                    stat_clr,
    input  logic [NCH-1:0]          prod_valid,
    input  logic [NCH-1:0]          prod_start,
    input  logic [NCH-1:0][AW-1:0]  prod_addr,
    input  logic [NCH-1:0][CW-1:0]  prod_qwc,
    input  logic [NCH-1:0][1:0]     prod_mode,
    input  logic [NCH-1:0][31:0]    prod_tag,
    input  logic [NCH-1:0]          cons_req,
    input  logic [NCH-1:0][AW-1:0]  cons_addr,
    input  logic [NCH-1:0][CW-1:0]  cons_qwc,
    input  logic [NCH-1:0][1:0]     cons_mode,
    input  logic [NCH-1:0][31:0]    cons_tag,
    input  logic [FW-1:0]           fifo_free,
    output logic [AW-1:0]           stall_addr_o,
    output logic [NCH-1:0]          drain_hold_o,
    output logic                    stall_status_o,
    output logic                    stall_irq_o
);

    localparam int SELW = 2;

    logic [7:0]      ctl_q;
    logic [SELW-1:0] src_sel;
    logic [SELW-1:0] drain_sel;
    logic            irq_mask;
    logic            chk_req, chk_applies, chk_block;
    logic            enter;

    assign src_sel   = ctl_q[5:4];
    assign drain_sel = ctl_q[7:6];
    assign irq_mask  = ctl_q[0];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctl_q <= '0;
        end else if (ctl_we) begin
            ctl_q <= ctl_wdata;
        end
    end

    stall_src_track #(.NCH(NCH), .AW(AW), .CW(CW), .SELW(SELW)) u_src (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_sel    (src_sel),
        .p_valid    (prod_valid),
        .p_start    (prod_start),
        .p_addr     (prod_addr),
        .p_qwc      (prod_qwc),
        .p_mode     (prod_mode),
        .p_tag      (prod_tag),
        .stall_addr (stall_addr_o)
    );

    stall_drain_check #(.NCH(NCH), .AW(AW), .CW(CW), .FW(FW), .SELW(SELW),
                        .FIFO_CH(FIFO_CH)) u_chk_path (
        .drain_sel   (drain_sel),
        .c_req       (cons_req),
        .c_addr      (cons_addr),
        .c_qwc       (cons_qwc),
        .c_mode      (cons_mode),
        .c_tag       (cons_tag),
        .c_fifo_free (fifo_free),
        .stall_addr  (stall_addr_o),
        .chk_req     (chk_req),
        .chk_applies (chk_applies),
        .chk_block   (chk_block)
    );

    stall_hold_fsm #(.NCH(NCH), .SELW(SELW)) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .drain_sel   (drain_sel),
        .chk_req     (chk_req),
        .chk_applies (chk_applies),
        .chk_block   (chk_block),
        .hold_vec    (drain_hold_o),
        .enter       (enter)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stall_status_o <= 1'b0;
        end else if (enter) begin
            stall_status_o <= 1'b1;
        end else if (stat_clr) begin
            stall_status_o <= 1'b0;
        end
    end

    assign stall_irq_o = stall_status_o & irq_mask;

endmodule

// File: rtl/dma_stall_ctrl_chk.sv
module dma_stall_ctrl_chk #(
    parameter int NCH = 3,
    parameter int AW  = 32
) (
    input logic           clk,
    input logic           rst_n,
    input logic [7:0]     ctl_q,
    input logic [AW-1:0]  stall_addr,
    input logic [NCH-1:0] hold,
    input logic           status,
    input logic           irq,
    input logic           stat_clr,
    input logic [NCH-1:0] cons_req,
    input logic [NCH-1:0] prod_valid
);

    // R2: with no source selected, the watermark never moves
    a_r2_no_source: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q[5:4] == 2'd0) |=> $stable(stall_addr));

    // R2: with no producer event, the watermark never moves
    a_r2_quiet_producers: assert property (@(posedge clk) disable iff (!rst_n)
        (prod_valid == '0) |=> $stable(stall_addr));

    // R6: at most one consumer held
    a_r6_one_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hold));

    // R8: a hold only appears after a consumer request
    a_r8_hold_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|hold) |-> $past(|cons_req));

    // R11: entering the hold raises the status bit
    a_r11_entry_sets: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(|hold) |-> status);

    // R11: status is sticky without a clear pulse
    a_r11_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status && !stat_clr) |=> status);

    // R12: the interrupt is never high without the status bit
    a_r12_irq_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);

endmodule

bind dma_stall_ctrl dma_stall_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .ctl_q      (ctl_q),
    .stall_addr (stall_addr_o),
    .hold       (drain_hold_o),
    .status     (stall_status_o),
    .irq        (stall_irq_o),
    .stat_clr   (stat_clr),
    .cons_req   (cons_req),
    .prod_valid (prod_valid)
);

// File: tb/dma_stall_ctrl_tb.sv
module dma_stall_ctrl_tb;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             ctl_we = 1'b0;
    logic [7:0]       ctl_wdata = '0;
    logic             stat_clr = 1'b0;
    logic [2:0]       prod_valid = '0;
    logic [2:0]       prod_start = '0;
    logic [2:0][31:0] prod_addr = '0;
    logic [2:0][15:0] prod_qwc = '0;
    logic [2:0][1:0]  prod_mode = '0;
    logic [2:0][31:0] prod_tag = '0;
    logic [2:0]       cons_req = '0;
    logic [2:0][31:0] cons_addr = '0;
    logic [2:0][15:0] cons_qwc = '0;
    logic [2:0][1:0]  cons_mode = '0;
    logic [2:0][31:0] cons_tag = '0;
    logic [7:0]       fifo_free = '0;
    logic [31:0]      stall_addr_o;
    logic [2:0]       drain_hold_o;
    logic             stall_status_o;
    logic             stall_irq_o;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    dma_stall_ctrl u_dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic write_ctl(input logic [7:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        step();
        ctl_we = 1'b0;
    endtask

    task automatic prod(input int ch, input logic st, input logic [31:0] a,
                        input logic [15:0] q, input logic [1:0] m, input logic [31:0] t);
        prod_valid[ch] = 1'b1; prod_start[ch] = st; prod_addr[ch] = a;
        prod_qwc[ch] = q; prod_mode[ch] = m; prod_tag[ch] = t;
        step();
        prod_valid = '0; prod_start = '0;
    endtask

    task automatic cons_set(input int ch, input logic [31:0] a, input logic [15:0] q,
                            input logic [1:0] m, input logic [31:0] t);
        cons_req[ch] = 1'b1; cons_addr[ch] = a; cons_qwc[ch] = q;
        cons_mode[ch] = m; cons_tag[ch] = t;
    endtask

    task automatic cons(input int ch, input logic [31:0] a, input logic [15:0] q,
                        input logic [1:0] m, input logic [31:0] t);
        cons_set(ch, a, q, m, t);
        step();
        cons_req = '0;
    endtask

    task automatic t_reset();
        check("R1 addr", stall_addr_o, 0);
        check("R1 hold", {29'd0, drain_hold_o}, 0);
        check("R1 status", {31'd0, stall_status_o}, 0);
        check("R1 irq", {31'd0, stall_irq_o}, 0);
    endtask

    task automatic t_source_select();
        write_ctl(8'h10);
        prod(1, 0, 32'h100, 0, 2'd0, 0);
        check("R2 unselected producer ignored", stall_addr_o, 32'h0);
        prod(0, 0, 32'h200, 0, 2'd0, 0);
        check("R3 normal done loads", stall_addr_o, 32'h200);
    endtask

    task automatic t_chain_publish();
        prod(0, 0, 32'h300, 0, 2'd1, 32'h1000_0000);
        check("R3 chain other tag no load", stall_addr_o, 32'h200);
        prod(0, 0, 32'h340, 0, 2'd1, 32'h0000_1234);
        check("R3 chain tag0 done loads", stall_addr_o, 32'h340);
        prod(0, 0, 32'h380, 5, 2'd0, 0);
        check("R3 nonzero count no load", stall_addr_o, 32'h340);
        prod(0, 1, 32'h400, 8, 2'd1, 32'h0);
        check("R4 packet start loads start addr", stall_addr_o, 32'h400);
    endtask

    task automatic t_interleave();
        write_ctl(8'h30);
        prod(2, 0, 32'h800, 4, 2'd2, 0);
        check("R5 interleave not done", stall_addr_o, 32'h400);
        prod(2, 0, 32'h800, 0, 2'd2, 0);
        check("R5 interleave done loads", stall_addr_o, 32'h800);
    endtask

    task automatic t_range();
        write_ctl(8'h71);
        cons(1, 32'h900, 1, 2'd0, 0);
        check("R6 unselected consumer not held", {29'd0, drain_hold_o}, 0);
        cons(0, 32'h7F0, 1, 2'd0, 0);
        check("R8 equal end proceeds", {29'd0, drain_hold_o}, 0);
        cons(0, 32'h7F0, 2, 2'd0, 0);
        check("R8 greater end held", {29'd0, drain_hold_o}, 32'h1);
        check("R11 status on entry", {31'd0, stall_status_o}, 1);
        check("R12 irq with mask", {31'd0, stall_irq_o}, 1);
    endtask

    task automatic t_recheck_and_race();
        cons(0, 32'h7F0, 2, 2'd0, 0);
        check("R10 still blocked stays held", {29'd0, drain_hold_o}, 32'h1);
        stat_clr = 1'b1; step(); stat_clr = 1'b0;
        check("R11 clear pulse", {31'd0, stall_status_o}, 0);
        cons(0, 32'h7F0, 2, 2'd0, 0);
        check("R11 no set while staying held", {31'd0, stall_status_o}, 0);
        cons_set(0, 32'h7F0, 2, 2'd0, 0);
        prod(2, 0, 32'h810, 0, 2'd2, 0);
        cons_req = '0;
        check("R13 update same cycle", stall_addr_o, 32'h810);
        check("R13 judged on old address", {29'd0, drain_hold_o}, 32'h1);
        cons(0, 32'h7F0, 2, 2'd0, 0);
        check("R10 release on recheck", {29'd0, drain_hold_o}, 0);
    endtask

    task automatic t_applicability();
        cons(0, 32'h800, 4, 2'd1, 32'h1000_0000);
        check("R7 chain other tag not checked", {29'd0, drain_hold_o}, 0);
        cons(0, 32'h800, 4, 2'd2, 32'h4000_0000);
        check("R7 interleave not checked", {29'd0, drain_hold_o}, 0);
        stat_clr = 1'b1;
        cons(0, 32'h800, 4, 2'd1, 32'h4000_0000);
        stat_clr = 1'b0;
        check("R7 chain guarded tag held", {29'd0, drain_hold_o}, 32'h1);
        check("R11 entry beats clear", {31'd0, stall_status_o}, 1);
        write_ctl(8'h70);
        check("R12 masked irq", {31'd0, stall_irq_o}, 0);
        check("R12 status kept", {31'd0, stall_status_o}, 1);
        write_ctl(8'h30);
        check("R10 hold before drop", {29'd0, drain_hold_o}, 32'h1);
        step();
        check("R10 drop on deselect", {29'd0, drain_hold_o}, 0);
    endtask

    task automatic t_fifo_limit();
        write_ctl(8'hF0);
        fifo_free = 8'd4;
        cons(2, 32'h800, 10, 2'd0, 0);
        check("R9 fifo limits size", {29'd0, drain_hold_o}, 0);
        fifo_free = 8'd8;
        cons(2, 32'h800, 10, 2'd0, 0);
        check("R9 larger fifo held", {29'd0, drain_hold_o}, 32'h4);
        fifo_free = 8'd64;
        cons(2, 32'h800, 1, 2'd0, 0);
        check("R9 count limits size, release", {29'd0, drain_hold_o}, 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_source_select();
        t_chain_publish();
        t_interleave();
        t_range();
        t_recheck_and_race();
        t_applicability();
        t_fifo_limit();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule